// File: doc/BRIEF.md
# Staging ring with half-ring refill window

This block sits between a producer of packed bytes and a handshake sequencer that emits one output word per transfer beat. A transfer begins with a start pulse that carries its length in bytes. 32-bit input words arrive on a valid/ready stream. Each byte is looked up in a loadable translation table, and the table entry is written into a 256-entry circular store. The sequencer drains the store one word at a time over a second valid/ready stream.

Refill is not free-running. A fill limit sets how far the write index may run ahead. It starts one full ring ahead and moves forward by half a ring each time the reader crosses the middle or the end of the ring. The stager works in atomic bursts. After each burst it waits a fixed service delay, then services one pending boundary event per cycle. If both boundary events are pending when it looks, the reader has lapped the refill service. The block then raises an overrun and abandons the transfer.

Back-pressure works as follows. An input word is transferred when `in_valid` and `in_ready` are both high on a rising edge. `in_ready` never depends on `in_valid`. An output word is transferred when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value. `out_valid` never depends on `out_ready`.

Top module: `stage_ring`

## Requirements
- R1: After reset, `busy`, `in_ready`, `out_valid`, `overrun` and `underflow` are all low.
- R2: Each output word equals the translation-table entry addressed by the corresponding input byte. The table is written through `tbl_we`/`tbl_addr`/`tbl_data` while `busy` is low.
- R3: Bytes are taken from each 32-bit input word starting with bits [7:0], then [15:8], [23:16] and [31:24]. The unused upper bytes of the final word of a transfer are discarded.
- R4: A transfer of N bytes delivers exactly N output words in input order, and then `busy` falls.
- R5: At most 256 bytes are staged before the reader's first half-ring crossing. With the reader stalled, a long transfer accepts exactly 64 input words, then `in_ready` stays low while `out_valid` stays high.
- R6: Each time the reader completes a multiple of 128 words, the fill limit rises by 128. Reading 127 words of a stalled 600-byte transfer admits no new input. Reading the 128th admits exactly 32 more input words.
- R7: If both boundary events are pending when the stager services them, `overrun` rises and `busy` and `out_valid` drop in the same cycle. `overrun` is cleared by the next accepted start.
- R8: `out_ready` high while `busy` is high and `out_valid` is low sets the sticky `underflow` flag. The next accepted start clears it.
- R9: Table writes while `busy` is high have no effect.
- R10: `out_data` is stable while `out_valid` is high and `out_ready` is low. `in_ready` is high only while `busy` is high.
- R11: A start pulse while `busy` is high is ignored, and the running transfer keeps its length. A start with a length of zero is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (accepted when idle and length is non-zero) |
| xfer_len | input | LEN_W | Transfer length in bytes, sampled with `start` |
| busy | output | 1 | Transfer in progress |
| tbl_we | input | 1 | Translation table write strobe |
| tbl_addr | input | 8 | Table entry (byte value) to write |
| tbl_data | input | OUT_W | Output word stored for that byte value |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 32 | Packed input bytes, lowest byte first |
| out_valid | output | 1 | Staged word available |
| out_ready | input | 1 | Sequencer takes the word |
| out_data | output | OUT_W | Oldest staged word |
| overrun | output | 1 | Sticky: reader lapped the refill service |
| underflow | output | 1 | Sticky: read attempted on an empty ring |

## Verification
The bench holds the reader still in the middle of a 600-byte transfer. A design that refilled up to the read pointer would accept more than 64 words there, and one that advanced the limit at the wrong read count would admit input after 127 reads or fail to admit exactly 32 words after the 128th. The same transfer then drains at a third of full rate across two ring wraps, so wrong index masking or byte ordering shows up as mismatched words. A full-rate reader over a 512-byte transfer must trigger the overrun, which a design that cleared both events at once or checked them separately would miss. Table writes and start pulses during a transfer, a 37-byte transfer with a partial last word, and reads of an empty ring check the ignored-input and sticky-flag rules.

// File: rtl/stage_ring_pkg.sv
package stage_ring_pkg;
  localparam int BYTE_W = 8;
  localparam int TBL_DEPTH = 1 << BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SVC    = 2'd1,
    ST_BURST  = 2'd2,
    ST_SETTLE = 2'd3
  } stg_state_e;
endpackage

// File: rtl/sr_unpack.sv
module sr_unpack
  import stage_ring_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load_ok,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              take,
  input  logic              last_byte,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  logic [WORD_W-1:0] hold_q;
  logic              hold_vld_q;
  logic [LANE_W-1:0] lane_q;
  logic [BYTE_W-1:0] lane_byte [LANES];
  logic              drain;

  // one slice per lane; lane 0 is the least significant byte
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = hold_q[g*BYTE_W +: BYTE_W];
  end

  assign byte_val = lane_byte[lane_q];
  assign byte_vld = hold_vld_q;
  assign drain    = take && ((lane_q == LANE_W'(LANES - 1)) || last_byte);
  assign in_ready = load_ok && !hold_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      lane_q     <= '0;
    end else if (clear) begin
      hold_vld_q <= 1'b0;
      lane_q     <= '0;
    end else if (in_valid && in_ready) begin
      hold_q     <= in_data;
      hold_vld_q <= 1'b1;
      lane_q     <= '0;
    end else if (drain) begin
      hold_vld_q <= 1'b0;
      lane_q     <= '0;
    end else if (take) begin
      lane_q <= lane_q + LANE_W'(1);
    end
  end
endmodule

// File: rtl/sr_xlate.sv
module sr_xlate
  import stage_ring_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BYTE_W-1:0] waddr,
  input  logic [OUT_W-1:0]  wdata,
  input  logic [BYTE_W-1:0] raddr,
  output logic [OUT_W-1:0]  rdata
);
  logic [OUT_W-1:0] tbl_mem [TBL_DEPTH];

  always_ff @(posedge clk) begin
    if (we) tbl_mem[waddr] <= wdata;
  end

  assign rdata = tbl_mem[raddr];
endmodule

// File: rtl/sr_ring.sv
module sr_ring #(
  parameter int DEPTH = 256,
  parameter int OUT_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [OUT_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [OUT_W-1:0] rdata
);
  logic [OUT_W-1:0] ring_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ring_mem[waddr] <= wdata;
  end

  assign rdata = ring_mem[raddr];
endmodule

// File: rtl/sr_ctrl.sv
module sr_ctrl
  import stage_ring_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int LEN_W   = 16,
  parameter int SVC_LAT = 4,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             byte_vld,
  output logic             take,
  output logic             last_byte,
  output logic             load_ok,
  output logic             clear,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             busy,
  output logic             overrun,
  output logic             underflow
);
  localparam int HALF  = DEPTH / 2;
  localparam int CNT_W = LEN_W + 1;
  localparam int BL_W  = IDX_W + 1;
  localparam int SL_W  = $clog2(SVC_LAT + 1);

  stg_state_e       state_q;
  logic [CNT_W-1:0] wr_q, rd_q, fill_q, len_q;
  logic [CNT_W-1:0] remaining, room, chunk, rd_nxt;
  logic [BL_W-1:0]  burst_q;
  logic [SL_W-1:0]  settle_q;
  logic             half_q, wrap_q;
  logic             pop, ev_mark, ev_half, ev_wrap, finish, start_ok;

  assign busy      = (state_q != ST_IDLE);
  assign remaining = len_q - wr_q;
  assign room      = fill_q - wr_q;
  assign chunk     = (remaining < room) ? remaining : room;
  assign out_valid = busy && (wr_q != rd_q);
  assign pop       = out_valid && out_ready;
  assign rd_nxt    = rd_q + CNT_W'(1);
  assign ev_mark   = pop && (rd_nxt[IDX_W-2:0] == '0);
  assign ev_half   = ev_mark && rd_nxt[IDX_W-1];
  assign ev_wrap   = ev_mark && !rd_nxt[IDX_W-1];
  assign finish    = pop && (rd_nxt == len_q);
  assign start_ok  = start && !busy && (xfer_len != '0);
  assign load_ok   = (state_q == ST_BURST);
  assign take      = load_ok && byte_vld;
  assign last_byte = take && (remaining == CNT_W'(1));
  assign clear     = start_ok;
  assign wr_idx    = wr_q[IDX_W-1:0];
  assign rd_idx    = rd_q[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_q      <= '0;
      rd_q      <= '0;
      fill_q    <= '0;
      len_q     <= '0;
      burst_q   <= '0;
      settle_q  <= '0;
      half_q    <= 1'b0;
      wrap_q    <= 1'b0;
      overrun   <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (busy && out_ready && !out_valid) underflow <= 1'b1;
      if (pop)  rd_q <= rd_nxt;
      if (take) wr_q <= wr_q + CNT_W'(1);

      unique case (state_q)
        ST_IDLE: ;
        ST_SVC: begin
          if (half_q && wrap_q) begin
            overrun <= 1'b1;
            state_q <= ST_IDLE;
          end else if (half_q) begin
            half_q <= 1'b0;
            fill_q <= fill_q + CNT_W'(HALF);
          end else if (wrap_q) begin
            wrap_q <= 1'b0;
            fill_q <= fill_q + CNT_W'(HALF);
          end else if (chunk != '0) begin
            burst_q <= BL_W'(chunk);
            state_q <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (take) begin
            burst_q <= burst_q - BL_W'(1);
            if (burst_q == BL_W'(1)) begin
              settle_q <= SL_W'(SVC_LAT - 1);
              state_q  <= ST_SETTLE;
            end
          end
        end
        ST_SETTLE: begin
          if (settle_q == '0) state_q <= ST_SVC;
          else                settle_q <= settle_q - SL_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase

      if (ev_half) half_q <= 1'b1;
      if (ev_wrap) wrap_q <= 1'b1;
      if (finish)  state_q <= ST_IDLE;

      if (start_ok) begin
        state_q   <= ST_SVC;
        len_q     <= CNT_W'(xfer_len);
        wr_q      <= '0;
        rd_q      <= '0;
        fill_q    <= CNT_W'(DEPTH);
        half_q    <= 1'b0;
        wrap_q    <= 1'b0;
        overrun   <= 1'b0;
        underflow <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stage_ring.sv
module stage_ring
  import stage_ring_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int OUT_W   = 16,
  parameter int LEN_W   = 16,
  parameter int WORD_W  = 32,
  parameter int SVC_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              busy,
  input  logic              tbl_we,
  input  logic [BYTE_W-1:0] tbl_addr,
  input  logic [OUT_W-1:0]  tbl_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data,
  output logic              overrun,
  output logic              underflow
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              take, last_byte, load_ok, clear, byte_vld;
  logic [BYTE_W-1:0] byte_val;
  logic [OUT_W-1:0]  xl_word;
  logic [IDX_W-1:0]  wr_idx, rd_idx;

  sr_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .SVC_LAT(SVC_LAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
    .byte_vld(byte_vld), .take(take), .last_byte(last_byte),
    .load_ok(load_ok), .clear(clear), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .out_valid(out_valid), .out_ready(out_ready), .busy(busy),
    .overrun(overrun), .underflow(underflow)
  );

  sr_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load_ok(load_ok),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .take(take), .last_byte(last_byte),
    .byte_vld(byte_vld), .byte_val(byte_val)
  );

  sr_xlate #(.OUT_W(OUT_W)) u_xlate (
    .clk(clk), .we(tbl_we && !busy), .waddr(tbl_addr), .wdata(tbl_data),
    .raddr(byte_val), .rdata(xl_word)
  );

  sr_ring #(.DEPTH(DEPTH), .OUT_W(OUT_W)) u_ring (
    .clk(clk), .we(take), .waddr(wr_idx), .wdata(xl_word),
    .raddr(rd_idx), .rdata(out_data)
  );
endmodule

// File: rtl/stage_ring_chk.sv
module stage_ring_chk #(
  parameter int DEPTH = 256,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             overrun,
  input logic             underflow
);
  logic [21:0] acc_words, popped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_words <= '0;
      popped    <= '0;
    end else if (start && !busy) begin
      acc_words <= '0;
      popped    <= '0;
    end else begin
      if (in_valid && in_ready)   acc_words <= acc_words + 22'd1;
      if (out_valid && out_ready) popped    <= popped + 22'd1;
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (overrun || (out_valid && $stable(out_data))));

  // R10
  in_ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  // R4
  out_valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  // R7
  overrun_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> (!busy && !out_valid));

  // R8
  underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && out_ready && !out_valid) |=> underflow);

  // R5
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (({acc_words, 2'b00} - {2'b00, popped}) <= 24'(DEPTH + 4)));
endmodule

bind stage_ring stage_ring_chk #(.DEPTH(DEPTH), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .overrun(overrun), .underflow(underflow)
);

// File: tb/tb_stage_ring.sv
module tb_stage_ring;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] xfer_len = '0;
  logic        busy;
  logic        tbl_we = 1'b0;
  logic [7:0]  tbl_addr = '0;
  logic [15:0] tbl_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        overrun;
  logic        underflow;

  stage_ring dut (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len), .busy(busy),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .overrun(overrun), .underflow(underflow)
  );

  always #2.5 clk = ~clk;

  int total_chk = 0;
  int bad_chk = 0;
  int cyc = 0;
  int seed_b = 0;
  int xlen = 0;
  int src_ptr = 0;
  int out_cnt = 0;
  int cmode = 0;
  int cons_limit = 0;
  bit pen = 0;
  bit go = 0;
  int go_len = 0;
  bit tw_en = 0;
  logic [7:0]  tw_addr = '0;
  logic [15:0] tw_data = '0;
  bit busy_s, ovr_s, und_s, ov_s, ir_s;
  logic [15:0] exp_tbl [256];

  function automatic logic [7:0] bval(int j);
    return 8'((j * 7 + seed_b) & 255);
  endfunction

  function automatic logic [31:0] wval(int w);
    return {bval(4*w+3), bval(4*w+2), bval(4*w+1), bval(4*w)};
  endfunction

  function automatic logic [15:0] tblf(int a, int s);
    return 16'((a * 37 + s * 101) ^ (a << 8) ^ 16'h5a5a);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad_chk++;
      total_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // one cycle: drive at the falling edge, then let the rising edge act
  task automatic step();
    bit r;
    @(negedge clk);
    busy_s = busy; ovr_s = overrun; und_s = underflow;
    ov_s = out_valid; ir_s = in_ready;
    start = go; xfer_len = 16'(go_len); go = 0;
    tbl_we = tw_en; tbl_addr = tw_addr; tbl_data = tw_data; tw_en = 0;
    in_valid = pen && (src_ptr < (xlen + 3) / 4);
    in_data = wval(src_ptr);
    if (in_valid && in_ready) src_ptr++;
    case (cmode)
      1: r = out_valid;
      2: r = out_valid && (cyc % 3 == 0);
      3: r = out_valid && (out_cnt < cons_limit);
      4: r = 1'b1;
      default: r = 1'b0;
    endcase
    out_ready = r;
    if (out_valid && r) begin
      // R2 R3: table entry of the byte, bytes lowest first
      check(out_data == exp_tbl[bval(out_cnt)], "R2 R3 word", int'(out_data),
            int'(exp_tbl[bval(out_cnt)]));
      out_cnt++;
    end
    @(posedge clk);
  endtask

  task automatic do_start(int len, int seed);
    xlen = len; seed_b = seed; src_ptr = 0; out_cnt = 0;
    go = 1; go_len = len;
    step();
  endtask

  task automatic run_until_idle(int limit);
    int n = 0;
    do begin
      step();
      n++;
    end while (busy_s && n < limit);
  endtask

  task automatic load_table(int s);
    pen = 0; cmode = 0;
    for (int a = 0; a < 256; a++) begin
      exp_tbl[a] = tblf(a, s);
      tw_en = 1; tw_addr = 8'(a); tw_data = tblf(a, s);
      step();
    end
  endtask

  task automatic t_reset();
    pen = 0; cmode = 0;
    step();
    check(!busy_s, "R1 busy", int'(busy_s), 0);
    check(!ir_s, "R1 in_ready", int'(ir_s), 0);
    check(!ov_s, "R1 out_valid", int'(ov_s), 0);
    check(!ovr_s, "R1 overrun", int'(ovr_s), 0);
    check(!und_s, "R1 underflow", int'(und_s), 0);
  endtask

  task automatic t_basic(int seed);
    do_start(37, seed);
    pen = 1; cmode = 1;
    run_until_idle(2000);
    check(out_cnt == 37, "R4 R3 word count", out_cnt, 37);
    check(!busy_s, "R4 busy drop", int'(busy_s), 0);
    check(!ovr_s, "R7 overrun cleared", int'(ovr_s), 0);
    check(!und_s, "R8 underflow cleared", int'(und_s), 0);
    check(!ir_s, "R10 in_ready idle", int'(ir_s), 0);
  endtask

  task automatic t_underflow();
    do_start(8, 3);
    pen = 0; cmode = 4;
    repeat (10) step();
    check(und_s, "R8 underflow set", int'(und_s), 1);
    pen = 1; cmode = 1;
    run_until_idle(500);
    check(out_cnt == 8, "R4 count", out_cnt, 8);
    check(und_s, "R8 underflow sticky", int'(und_s), 1);
  endtask

  task automatic t_fill_window();
    do_start(600, 9);
    pen = 1; cmode = 3; cons_limit = 0;
    repeat (600) step();
    check(src_ptr == 64, "R5 words before first half", src_ptr, 64);
    check(!ir_s, "R5 in_ready low", int'(ir_s), 0);
    check(ov_s, "R5 out_valid high", int'(ov_s), 1);
    // R9: table writes during the transfer must not land
    for (int a = 0; a < 16; a++) begin
      tw_en = 1; tw_addr = 8'(a); tw_data = ~exp_tbl[a];
      step();
    end
    // R11: start while busy is ignored
    go = 1; go_len = 5;
    step();
    check(busy_s, "R11 still busy", int'(busy_s), 1);
    cons_limit = 127;
    repeat (300) step();
    check(out_cnt == 127, "R6 read count", out_cnt, 127);
    check(src_ptr == 64, "R6 no refill at 127", src_ptr, 64);
    cons_limit = 128;
    repeat (300) step();
    check(src_ptr == 96, "R6 refill after 128", src_ptr, 96);
    cmode = 2;
    run_until_idle(5000);
    check(out_cnt == 600, "R4 R11 full length", out_cnt, 600);
    check(!ovr_s, "R7 no overrun slow reader", int'(ovr_s), 0);
  endtask

  task automatic t_overrun();
    do_start(512, 21);
    pen = 1; cmode = 1;
    run_until_idle(3000);
    check(ovr_s, "R7 overrun raised", int'(ovr_s), 1);
    check(!ov_s, "R7 out_valid dropped", int'(ov_s), 0);
    check(!busy_s, "R7 busy dropped", int'(busy_s), 0);
    check(out_cnt < 512, "R7 transfer abandoned", out_cnt, 511);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    load_table(1);
    t_basic(4);
    t_underflow();
    t_basic(11);
    t_fill_window();
    t_overrun();
    // R9: after writes were refused, the old table still holds
    t_basic(5);
    summary();
    $finish;
  end
endmodule